// File: doc/BRIEF.md
# Timed Command Release Queue

This block buffers control commands in arrival order and hands each one to a downstream register-write port. A command may carry a 64-bit release time. The command at the head of the queue goes out once a free-running time counter has reached that time. A command without a release time goes out as soon as it becomes the head.

Order is strict. A head entry that is waiting for its time holds back everything behind it, even entries whose own times have already gone by. A timed command that reaches the head after its time has passed is still issued, at once, and a late marker goes out with it.

The source gets no timing backpressure, so the queue reports how many entries it holds. It also keeps a sticky flag that records any write attempted while the queue was full. The time counter can be loaded with a new value at any time.

Top module: `tcq_dispatch`

## Requirements
- R1: An untimed command is issued in the first cycle it is at the head. When it is pushed into an empty queue, `wr_strobe` is high in the cycle after the cycle that follows the accepting edge, which is two rising edges after it was offered.
- R2: A timed command (`in_timed`=1) at the head is issued in the first cycle in which `time_now` >= its timestamp, and never earlier.
- R3: Commands leave in exactly the order they were accepted, with their address and data unchanged. A waiting timed head blocks every later entry.
- R4: `wr_late` is 1 with a timed command only when its timestamp was strictly below `time_now` in the first cycle the command was at the head. Such a command is issued in that same cycle. An untimed command, and a timed one whose time was not yet passed on arrival (including equal), gives `wr_late`=0.
- R5: At most one command is issued per cycle. Eligible entries that follow one another are issued in consecutive cycles.
- R6: `fill_count` equals the number of entries held, up to DEPTH (default 64). `in_ready` is 0 exactly when `fill_count`=DEPTH, and a command offered then is not stored.
- R7: `ovf_flag` is set one edge after a cycle with `in_valid`=1 and `in_ready`=0. It stays set until `ovf_clear` is high at an edge, which clears it. When both happen in the same cycle, the clear wins.
- R8: `time_now` rises by one on every edge. When `time_load` is high at an edge, `time_now` takes `time_load_val` instead.
- R9: Reset (`rst_n`=0) empties the queue without issuing anything. It leaves `time_now`=0, `fill_count`=0, `in_ready`=1, `ovf_flag`=0, `wr_strobe`=0 and `wr_late`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| time_load | input | 1 | Load the time counter |
| time_load_val | input | 64 | Value to load |
| time_now | output | 64 | Current time counter |
| in_valid | input | 1 | Command offered |
| in_ready | output | 1 | Queue can accept |
| in_timed | input | 1 | Command carries a release time |
| in_time | input | 64 | Release time |
| in_addr | input | ADDR_W | Register address |
| in_data | input | DATA_W | Register data |
| wr_strobe | output | 1 | One-cycle write strobe per issued command |
| wr_addr | output | ADDR_W | Address of issued command |
| wr_data | output | DATA_W | Data of issued command |
| wr_late | output | 1 | Issued command was already late at the head |
| fill_count | output | $clog2(DEPTH+1) | Entries held |
| ovf_flag | output | 1 | Sticky write-while-full flag |
| ovf_clear | input | 1 | Clears `ovf_flag` |

## Verification
The issue decision is made in the same cycle from the head entry and the registered counter, and the write port is registered one edge later. A command's strobe therefore appears one edge after the cycle in which it became eligible, and two edges after it was pushed into an empty queue. `fill_count`, `in_ready`, `ovf_flag` and `time_now` each settle one edge after their cause. The bench drives and samples on falling edges. It recovers the issue cycle of each strobe as `time_now` minus one at that sample. It predicts each issue time from the push time, the previous issue time and the timestamp.

// File: rtl/tcq_pkg.sv
package tcq_pkg;
  parameter int unsigned TIME_W = 64;

  typedef logic [TIME_W-1:0] tstamp_t;

  // time has reached the requested release moment
  function automatic logic time_reached(input tstamp_t now, input tstamp_t due);
    return (now >= due);
  endfunction

  // release moment already lies behind the current time
  function automatic logic time_passed(input tstamp_t now, input tstamp_t due);
    return (due < now);
  endfunction

  // circular pointer advance for any depth
  function automatic int unsigned ptr_next(input int unsigned p, input int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction
endpackage

// File: rtl/tcq_timebase.sv
module tcq_timebase
  import tcq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    load,
  input  tstamp_t load_val,
  output tstamp_t now
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    now <= '0;
    else if (load) now <= load_val;
    else           now <= now + tstamp_t'(1);
  end
endmodule

// File: rtl/tcq_store.sv
module tcq_store
  import tcq_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned WORD_W = 113,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [WORD_W-1:0] push_word,
  input  logic              pop,
  output logic [WORD_W-1:0] head_word,
  output logic              empty,
  output logic              full,
  output logic [CNT_W-1:0]  count
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= PTR_W'(ptr_next(int'(wr_ptr), DEPTH));
      if (pop)  rd_ptr <= PTR_W'(ptr_next(int'(rd_ptr), DEPTH));
      case ({push, pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  assign head_word = mem[rd_ptr];
  assign empty     = (count == '0);
  assign full      = (count == CNT_W'(DEPTH));
endmodule

// File: rtl/tcq_release.sv
module tcq_release
  import tcq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    empty,
  input  logic    head_timed,
  input  tstamp_t head_due,
  input  tstamp_t now,
  output logic    fire,
  output logic    late
);
  logic head_fresh;   // head entry is in its first cycle at the head
  logic late_hold;    // lateness captured on that first cycle
  logic late_now;

  assign late_now = head_timed && time_passed(now, head_due);
  assign fire     = !empty && (!head_timed || time_reached(now, head_due));
  assign late     = head_timed && (head_fresh ? late_now : late_hold);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_fresh <= 1'b1;
      late_hold  <= 1'b0;
    end else begin
      head_fresh <= empty || fire;
      if (!empty && head_fresh) late_hold <= late_now;
    end
  end
endmodule

// File: rtl/tcq_dispatch.sv
module tcq_dispatch
  import tcq_pkg::*;
#(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              time_load,
  input  logic [TIME_W-1:0] time_load_val,
  output logic [TIME_W-1:0] time_now,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_timed,
  input  logic [TIME_W-1:0] in_time,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  output logic              wr_strobe,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_late,
  output logic [CNT_W-1:0]  fill_count,
  output logic              ovf_flag,
  input  logic              ovf_clear
);
  localparam int unsigned ENT_W = 1 + TIME_W + ADDR_W + DATA_W;

  logic              push, fire, late, empty, full;
  logic [ENT_W-1:0]  head_word;
  logic              head_timed;
  tstamp_t           head_due;
  logic [ADDR_W-1:0] head_addr;
  logic [DATA_W-1:0] head_data;

  tcq_timebase u_time (
    .clk(clk), .rst_n(rst_n), .load(time_load), .load_val(time_load_val), .now(time_now)
  );

  assign push     = in_valid && !full;
  assign in_ready = !full;

  tcq_store #(.DEPTH(DEPTH), .WORD_W(ENT_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .push(push), .push_word({in_timed, in_time, in_addr, in_data}),
    .pop(fire), .head_word(head_word),
    .empty(empty), .full(full), .count(fill_count)
  );

  assign head_timed = head_word[ENT_W-1];
  assign head_due   = head_word[ENT_W-2 -: TIME_W];
  assign head_addr  = head_word[DATA_W +: ADDR_W];
  assign head_data  = head_word[DATA_W-1:0];

  tcq_release u_release (
    .clk(clk), .rst_n(rst_n), .empty(empty),
    .head_timed(head_timed), .head_due(head_due), .now(time_now),
    .fire(fire), .late(late)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_strobe <= 1'b0;
      wr_late   <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      ovf_flag  <= 1'b0;
    end else begin
      wr_strobe <= fire;
      wr_late   <= fire && late;
      if (fire) begin
        wr_addr <= head_addr;
        wr_data <= head_data;
      end
      if (ovf_clear)             ovf_flag <= 1'b0;
      else if (in_valid && full) ovf_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/tcq_checker.sv
module tcq_checker #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned CNT_W = 7,
  parameter int unsigned TIME_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              time_load,
  input logic [TIME_W-1:0] time_load_val,
  input logic [TIME_W-1:0] time_now,
  input logic              in_valid,
  input logic              in_ready,
  input logic              ovf_clear,
  input logic              ovf_flag,
  input logic [CNT_W-1:0]  fill_count,
  input logic              wr_strobe,
  input logic              wr_late,
  input logic              pop
);
  p_fill_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fill_count <= CNT_W'(DEPTH));
  p_ready_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_count == CNT_W'(DEPTH)) |-> !in_ready);
  p_fill_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (fill_count == $past(fill_count)) || (fill_count == $past(fill_count) + CNT_W'(1))
             || (fill_count + CNT_W'(1) == $past(fill_count)));
  p_ovf_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready && !ovf_clear) |=> ovf_flag);
  p_ovf_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clear) |=> ovf_flag);
  p_ovf_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_clear |=> !ovf_flag);
  p_time_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !time_load |=> time_now == $past(time_now) + TIME_W'(1));
  p_time_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    time_load |=> time_now == $past(time_load_val));
  p_pop_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> wr_strobe);
  p_idle_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !pop |=> !wr_strobe);
  p_late_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_late |-> wr_strobe);
endmodule

bind tcq_dispatch tcq_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W), .TIME_W(tcq_pkg::TIME_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .time_load(time_load), .time_load_val(time_load_val),
  .time_now(time_now), .in_valid(in_valid), .in_ready(in_ready), .ovf_clear(ovf_clear),
  .ovf_flag(ovf_flag), .fill_count(fill_count), .wr_strobe(wr_strobe), .wr_late(wr_late),
  .pop(fire)
);

// File: tb/tcq_dispatch_bench.sv
`timescale 1ns/1ps
module tcq_dispatch_bench;
  localparam int DEPTH = 64;
  localparam int NV = 12;
  localparam logic [63:0] BASE = 64'd1000;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        time_load = 1'b0;
  logic [63:0] time_load_val = '0, time_now;
  logic        in_valid = 1'b0, in_ready, in_timed = 1'b0;
  logic [63:0] in_time = '0;
  logic [15:0] in_addr = '0, wr_addr;
  logic [31:0] in_data = '0, wr_data;
  logic        wr_strobe, wr_late, ovf_flag, ovf_clear = 1'b0;
  logic [6:0]  fill_count;

  always #2.5 clk = ~clk;

  tcq_dispatch u_tcq_dispatch (
    .clk(clk), .rst_n(rst_n), .time_load(time_load), .time_load_val(time_load_val),
    .time_now(time_now), .in_valid(in_valid), .in_ready(in_ready), .in_timed(in_timed),
    .in_time(in_time), .in_addr(in_addr), .in_data(in_data), .wr_strobe(wr_strobe),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_late(wr_late), .fill_count(fill_count),
    .ovf_flag(ovf_flag), .ovf_clear(ovf_clear)
  );

  typedef struct packed {
    logic        timed;
    logic [15:0] ts_rel;
    logic [15:0] gap;
    logic [15:0] addr;
    logic [31:0] data;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{1'b0, 16'd0,   16'd0,   16'h0010, 32'hA000_0000},
    '{1'b1, 16'd40,  16'd1,   16'h0011, 32'hA000_0001},
    '{1'b0, 16'd0,   16'd0,   16'h0012, 32'hA000_0002},
    '{1'b1, 16'd5,   16'd0,   16'h0013, 32'hA000_0003},
    '{1'b0, 16'd0,   16'd0,   16'h0014, 32'hA000_0004},
    '{1'b1, 16'd41,  16'd2,   16'h0015, 32'hA000_0005},
    '{1'b1, 16'd100, 16'd0,   16'h0016, 32'hA000_0006},
    '{1'b1, 16'd100, 16'd0,   16'h0017, 32'hA000_0007},
    '{1'b0, 16'd0,   16'd0,   16'h0018, 32'hA000_0008},
    '{1'b1, 16'd200, 16'd150, 16'h0019, 32'hA000_0009},
    '{1'b1, 16'd201, 16'd0,   16'h001A, 32'hA000_000A},
    '{1'b0, 16'd0,   16'd60,  16'h001B, 32'hA000_000B}
  };

  int n_vec = 0, n_bad = 0, rec_n = 0, strobes = 0;
  bit done = 0;
  logic [15:0] rec_addr [64];
  logic [31:0] rec_data [64];
  logic        rec_late [64];
  logic [63:0] rec_fire [64];
  logic [63:0] exp_fire [NV];
  logic        exp_late [NV];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // record every strobe; time_now - 1 is the cycle in which the decision was taken
  always @(negedge clk) begin
    if (wr_strobe) begin
      strobes++;
      if (rec_n < 64) begin
        rec_addr[rec_n] = wr_addr;
        rec_data[rec_n] = wr_data;
        rec_late[rec_n] = wr_late;
        rec_fire[rec_n] = time_now - 64'd1;
        rec_n++;
      end
    end
  end

  task automatic push(input logic t, input logic [63:0] ts, input logic [15:0] a,
                      input logic [31:0] d, output logic [63:0] pt);
    chk(in_ready == 1'b1, "R6 ready before push", 64'(in_ready), 64'd1);
    in_valid = 1'b1; in_timed = t; in_time = ts; in_addr = a; in_data = d;
    pt = time_now;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] pt, prev_fire, avail, ts;
    int base_strobes;

    // R9 reset state
    repeat (3) @(negedge clk);
    chk(fill_count == 0, "R9 fill after reset", 64'(fill_count), 0);
    chk(in_ready == 1'b1, "R9 ready after reset", 64'(in_ready), 1);
    chk(wr_strobe == 1'b0 && wr_late == 1'b0, "R9 strobe after reset", 64'(wr_strobe), 0);
    chk(ovf_flag == 1'b0, "R9 ovf after reset", 64'(ovf_flag), 0);
    chk(time_now == 0, "R9 time after reset", time_now, 0);
    rst_n = 1'b1;

    // R8 load and count
    @(negedge clk);
    time_load = 1'b1; time_load_val = BASE;
    @(negedge clk);
    time_load = 1'b0;
    chk(time_now == BASE, "R8 load value", time_now, BASE);
    @(negedge clk);
    chk(time_now == BASE + 1, "R8 count", time_now, BASE + 1);

    // vector table: R1 R2 R3 R4 R5
    prev_fire = '0;
    for (int i = 0; i < NV; i++) begin
      repeat (VEC[i].gap) @(negedge clk);
      ts = BASE + 64'(VEC[i].ts_rel);
      push(VEC[i].timed, ts, VEC[i].addr, VEC[i].data, pt);
      avail = pt + 1;
      if (i > 0 && prev_fire + 1 > avail) avail = prev_fire + 1;
      exp_late[i] = VEC[i].timed && (ts < avail);
      exp_fire[i] = (VEC[i].timed && ts > avail) ? ts : avail;
      prev_fire = exp_fire[i];
    end
    for (int w = 0; w < 2000 && rec_n < NV; w++) @(negedge clk);
    chk(rec_n == NV, "R3 command count", 64'(rec_n), 64'(NV));
    for (int i = 0; i < NV; i++) begin
      chk(rec_addr[i] == VEC[i].addr, "R3 order addr", 64'(rec_addr[i]), 64'(VEC[i].addr));
      chk(rec_data[i] == VEC[i].data, "R3 order data", 64'(rec_data[i]), 64'(VEC[i].data));
      chk(rec_fire[i] == exp_fire[i], VEC[i].timed ? "R2 release cycle" : "R1 release cycle",
          rec_fire[i], exp_fire[i]);
      chk(rec_late[i] == exp_late[i], "R4 late flag", 64'(rec_late[i]), 64'(exp_late[i]));
      if (i > 0 && exp_fire[i] == exp_fire[i-1] + 1)
        chk(rec_fire[i] == rec_fire[i-1] + 1, "R5 back-to-back", rec_fire[i], rec_fire[i-1] + 1);
    end

    // R6 fill to full with far-future timed commands
    base_strobes = strobes;
    time_load = 1'b1; time_load_val = 64'd0;
    @(negedge clk);
    time_load = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      in_valid = 1'b1; in_timed = 1'b1; in_time = 64'hFFFF_0000;
      in_addr = 16'(i); in_data = 32'(i);
      @(negedge clk);
    end
    in_valid = 1'b0;
    chk(fill_count == 7'(DEPTH), "R6 fill at full", 64'(fill_count), 64'(DEPTH));
    chk(in_ready == 1'b0, "R6 ready at full", 64'(in_ready), 0);
    chk(ovf_flag == 1'b0, "R7 no ovf yet", 64'(ovf_flag), 0);
    chk(strobes == base_strobes, "R2 future head waits", 64'(strobes), 64'(base_strobes));

    // R7 overflow set, sticky, clear, clear priority
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(ovf_flag == 1'b1, "R7 ovf set", 64'(ovf_flag), 1);
    chk(fill_count == 7'(DEPTH), "R6 write while full dropped", 64'(fill_count), 64'(DEPTH));
    repeat (3) @(negedge clk);
    chk(ovf_flag == 1'b1, "R7 ovf sticky", 64'(ovf_flag), 1);
    ovf_clear = 1'b1;
    @(negedge clk);
    ovf_clear = 1'b0;
    chk(ovf_flag == 1'b0, "R7 ovf cleared", 64'(ovf_flag), 0);
    in_valid = 1'b1; ovf_clear = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; ovf_clear = 1'b0;
    chk(ovf_flag == 1'b0, "R7 clear wins", 64'(ovf_flag), 0);

    // R9 reset with a full queue
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(fill_count == 0, "R9 queue emptied", 64'(fill_count), 0);
    chk(in_ready == 1'b1, "R9 ready after flush", 64'(in_ready), 1);
    chk(strobes == base_strobes, "R9 nothing issued", 64'(strobes), 64'(base_strobes));

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule